// File: doc/BRIEF.md
# Dual-Input Edge-Qualified Binary Counter

This block is a 4-bit binary up-counter with two count inputs. One input steps the count on its rising edge and the other on its falling edge. Whichever input is not used as the clock acts as a level enable for the other. An active-high master clear forces the count to zero and holds it there. A free-running system clock samples all three inputs, so the block is a single clock domain. Two instances side by side give a dual counter with fully independent channels.

Each input passes through a two-stage synchronizer. An edge is found by comparing the synchronized sample with the sample taken one system cycle earlier. The enable level for an edge is the other input's level in that earlier sample, meaning its level just before the edge. A two-state controller names the counter's mode. It is MODE_CLEAR while the synchronized clear is high and MODE_COUNT otherwise. MODE_CLEAR goes to MODE_COUNT when the synchronized clear falls, and MODE_COUNT goes to MODE_CLEAR when it rises. From any input change to a change on q there are three system clock edges.

Top module: `edge_qual_counter`

## Requirements
- R1: While rst_n is low, q is 4'b0000, where q[0] is the least significant bit and the count is plain binary.
- R2: A low-to-high change of cp0 while cp1 was high before the change raises q by one on the third system clock edge after the change.
- R3: A high-to-low change of cp1 while cp0 was low before the change raises q by one, with the same three-edge latency.
- R4: A high-to-low change of cp0 or a low-to-high change of cp1 never changes q, whatever the other input's level.
- R5: A rising cp0 while cp1 was low, or a falling cp1 while cp0 was high, leaves q unchanged.
- R6: If cp0 rises and cp1 falls in the same system cycle, starting from cp0 low and cp1 high, q advances by exactly one.
- R7: While mr is high, q is forced to 4'b0000 and stays there whatever edges arrive on cp0 and cp1. A clear and an edge that arrive together leave q at zero.
- R8: Releasing mr does not step q by itself. Counting resumes at the first qualifying edge after mr goes low.
- R9: A qualified step from 4'b1111 wraps q to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | asynchronous active-low system reset |
| cp0 | input | 1 | count input, rising edge active |
| cp1 | input | 1 | count input, falling edge active |
| mr | input | 1 | master clear, active high |
| q | output | 4 | binary count |

## Verification
The bench walks both inputs through every edge and level pairing in the function table. A decoder that checked the enable level after the edge instead of before it would either miss the simultaneous rise of cp0 and fall of cp1, or count it twice. The bench also checks that edges arriving under a held clear do not leak into the count, and that releasing the clear does not itself cause a step. It runs the count from 15 to 0 to expose a wrap that saturates or carries into a wider register.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
    typedef enum logic {
        MODE_CLEAR = 1'b0,
        MODE_COUNT = 1'b1
    } mode_t;
endpackage

// File: rtl/eqc_input_sync.sv
module eqc_input_sync #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] synced
);
    logic [LANES-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/eqc_edge_qualifier.sv
module eqc_edge_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl0,
    input  logic lvl1,
    output logic step
);
    logic prev0, prev1;
    logic rise0, fall0, rise1, fall1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev0 <= 1'b0;
            prev1 <= 1'b0;
        end else begin
            prev0 <= lvl0;
            prev1 <= lvl1;
        end
    end

    always_comb begin
        rise0 = lvl0 & ~prev0;
        fall0 = ~lvl0 & prev0;
        rise1 = lvl1 & ~prev1;
        fall1 = ~lvl1 & prev1;
        step  = (rise0 & prev1) | (fall1 & ~prev0);
    end

    // R4
    wrong_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall0 || rise1) && !rise0 && !fall1) |-> !step);

    // R5
    bad_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise0 && !prev1 && !(fall1 && !prev0)) ||
         (fall1 && prev0 && !(rise0 && prev1))) |-> !step);
endmodule

// File: rtl/eqc_count_core.sv
module eqc_count_core
    import eqc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] TOP_COUNT = {WIDTH{1'b1}};

    mode_t mode_q, mode_d;

    always_comb begin
        unique case (mode_q)
            MODE_CLEAR: mode_d = clear ? MODE_CLEAR : MODE_COUNT;
            MODE_COUNT: mode_d = clear ? MODE_CLEAR : MODE_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_CLEAR;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (mode_d)
                MODE_CLEAR: q <= '0;
                MODE_COUNT: if (step) q <= q + 1'b1;
            endcase
        end
    end

    // R7
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CLEAR) |-> (q == '0));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && q != TOP_COUNT) |=> (q == $past(q) + 1'b1));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && q == TOP_COUNT) |=> (q == '0));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(q));
endmodule

// File: rtl/edge_qual_counter.sv
module edge_qual_counter #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp0,
    input  logic             cp1,
    input  logic             mr,
    output logic [WIDTH-1:0] q
);
    localparam int LANES = 3;

    logic [LANES-1:0] synced;
    logic             step;

    eqc_input_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({mr, cp1, cp0}),
        .synced (synced)
    );

    eqc_edge_qualifier u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl0  (synced[0]),
        .lvl1  (synced[1]),
        .step  (step)
    );

    eqc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (synced[2]),
        .step  (step),
        .q     (q)
    );
endmodule

// File: tb/edge_qual_counter_test.sv
module edge_qual_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cp0 = 1'b0, cp1 = 1'b0, mr = 1'b0;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;
    logic       p0 = 1'b0, p1 = 1'b0;
    logic [3:0] model = 4'd0;

    always #4 clk = ~clk;

    edge_qual_counter uut (
        .clk(clk), .rst_n(rst_n), .cp0(cp0), .cp1(cp1), .mr(mr), .q(q)
    );

    // each entry: {cp0, cp1, mr, expected q}
    localparam int NVEC = 21;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_1_0_0000, 7'b1_1_0_0001, 7'b0_1_0_0001, 7'b1_1_0_0010,
        7'b0_1_0_0010, 7'b0_0_0_0011, 7'b0_1_0_0011, 7'b0_0_0_0100,
        7'b1_0_0_0100, 7'b1_1_0_0100, 7'b1_0_0_0100, 7'b0_1_0_0100,
        7'b1_0_0_0101, 7'b0_1_0_0101, 7'b1_1_0_0110, 7'b1_1_1_0000,
        7'b0_1_1_0000, 7'b1_1_1_0000, 7'b1_1_0_0000, 7'b0_1_0_0000,
        7'b1_1_0_0001
    };

    function automatic string tag_of(int i);
        case (i)
            0, 2, 9, 11: return "R4";
            1, 3, 14:    return "R2";
            5, 7:        return "R3";
            8, 10:       return "R5";
            12:          return "R6";
            15, 16, 17:  return "R7";
            default:     return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%0d expected %0d", tag, q, exp);
        end
    endtask

    task automatic drive(logic c0, logic c1, logic m);
        @(negedge clk);
        cp0 = c0; cp1 = c1; mr = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(logic c0, logic c1, logic m, string tag);
        drive(c0, c1, m);
        if (m) model = 4'd0;
        else if ((c0 && !p0 && p1) || (!c1 && p1 && !p0)) model = model + 4'd1;
        p0 = c0; p1 = c1;
        check(tag, model);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: q=%0d expected end of run", q);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 4'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 4'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][6], VEC[i][5], VEC[i][4]);
            check(tag_of(i), VEC[i][3:0]);
        end
        p0 = 1'b1; p1 = 1'b1; model = 4'd1;

        // R9: run up to 15, then wrap
        for (int k = 0; k < 14; k++) begin
            apply(1'b0, 1'b1, 1'b0, "R4");
            apply(1'b1, 1'b1, 1'b0, "R2");
        end
        check("R9", 4'd15);
        apply(1'b0, 1'b1, 1'b0, "R4");
        apply(1'b0, 1'b0, 1'b0, "R3");
        check("R9", 4'd0);

        // R7: clear arriving with a qualifying edge wins
        apply(1'b0, 1'b1, 1'b0, "R4");
        apply(1'b1, 1'b1, 1'b0, "R2");
        apply(1'b0, 1'b1, 1'b0, "R4");
        apply(1'b1, 1'b1, 1'b1, "R7");
        apply(1'b0, 1'b1, 1'b1, "R7");
        apply(1'b0, 1'b0, 1'b1, "R7");
        apply(1'b0, 1'b0, 1'b0, "R8");
        apply(1'b0, 1'b1, 1'b0, "R8");
        apply(1'b0, 1'b0, 1'b0, "R8");
        check("R8", 4'd1);

        // R1: system reset mid-count
        apply(1'b0, 1'b1, 1'b0, "R4");
        apply(1'b1, 1'b1, 1'b0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 4'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule